// File: doc/BRIEF.md
# Out-of-Order Reservation-Station Scheduler

This block is the timing core of a dynamically scheduled processor back end. It accepts at most one instruction per cycle from an in-order issue queue. Each instruction names an operation class, a destination tag and two source tags. A source tag is marked as waiting when its value is still being produced. The block places the instruction in a reservation station of its class. It then watches the single result bus for the tags that the instruction still needs.

An instruction starts once both operands are present and a unit of its class is idle. Execution takes a fixed number of cycles. The finished instruction then competes for the one result bus, and the oldest finished instruction wins. Units are not pipelined. A unit, and the station that feeds it, stays held from the start of execution through the cycle in which the result is written. Instructions that produce no register value, such as stores and branches, retire through a separate done port and never take the bus.

Each start, bus write and bus-free retirement is reported with the instruction's tag. A surrounding model can therefore rebuild the issue, execute and write-back cycles of every instruction. Operand values, memory and branch outcomes are not handled here.

Top module: `tomasulo_sched`

## Requirements
- R1: After reset, `in_ready` is 1 and `ex_valid`, `cdb_valid` and `nb_valid` are all 0.
- R2: Class codes are: 0 integer (1 unit, 5 stations, latency 1), 1 FP add (1 unit, 4 stations, latency 6), 2 and 3 FP multiply/divide (2 units, 4 stations, latency 12). An independent instruction accepted in cycle c on an idle class starts in cycle c+1 and writes the bus in cycle c+1+L, where L is the latency of its class.
- R3: Units are not pipelined. A unit whose occupant writes back in cycle x starts nothing before cycle x+1.
- R4: The two multiply/divide units run at the same time. The oldest ready instruction takes the idle unit with the lowest index.
- R5: At most one result is written per cycle, and the oldest finished instruction wins. A loser keeps its unit and its station until it writes.
- R6: A source tag seen on the bus in cycle x lets its consumer start in cycle x+1 at the earliest. This also holds when x is the consumer's own issue cycle.
- R7: An instruction with `in_nobus`=1 never appears on the bus. It is reported on `nb_tag` in the cycle after its execution ends, and then frees its station.
- R8: `in_ready` is 0 while every station of the offered class is held. A station freed at the end of cycle x accepts an instruction in cycle x+1.
- R9: When several ready instructions contend for one unit, the oldest in issue order starts first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue request |
| in_ready | output | 1 | A station of the offered class is free |
| in_cls | input | 2 | Operation class code |
| in_nobus | input | 1 | Instruction produces no bus result (store, branch) |
| in_dst | input | TAG_W | Destination tag |
| in_s1_wait | input | 1 | Source 1 still being produced |
| in_s1 | input | TAG_W | Source 1 producer tag |
| in_s2_wait | input | 1 | Source 2 still being produced |
| in_s2 | input | TAG_W | Source 2 producer tag |
| ex_valid | output | NU | Per unit: execution starts this cycle |
| ex_tag | output | NU*TAG_W | Per unit: tag of the starting instruction |
| cdb_valid | output | 1 | Result bus write this cycle |
| cdb_tag | output | TAG_W | Tag written on the result bus |
| nb_valid | output | 1 | Bus-free retirement this cycle |
| nb_tag | output | TAG_W | Tag of the bus-free retirement |

## Verification
A wrong internal state shows at the ports within a few cycles. A lost operand wakeup or a wrong age compare moves a start or a write-back by at least one cycle. A stuck busy flag delays the next start on its unit until the run ends. A station that is never released lowers `in_ready` as soon as that class fills. The sweeps measure every start and write cycle against arithmetic expectations, so a shift of one cycle in any counter or in any capture path becomes a miscompare.

// File: rtl/tomasulo_sched.sv
module tomasulo_sched #(
  parameter int TAG_W = 5,
  parameter int SEQ_W = 6,
  parameter int NRS_I = 5,
  parameter int NRS_A = 4,
  parameter int NRS_M = 4,
  parameter int NU_I  = 1,
  parameter int NU_A  = 1,
  parameter int NU_M  = 2,
  parameter int LAT_I = 1,
  parameter int LAT_A = 6,
  parameter int LAT_M = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [1:0]                 in_cls,
  input  logic                       in_nobus,
  input  logic [TAG_W-1:0]           in_dst,
  input  logic                       in_s1_wait,
  input  logic [TAG_W-1:0]           in_s1,
  input  logic                       in_s2_wait,
  input  logic [TAG_W-1:0]           in_s2,
  output logic [NU_I+NU_A+NU_M-1:0]  ex_valid,
  output logic [(NU_I+NU_A+NU_M)*TAG_W-1:0] ex_tag,
  output logic                       cdb_valid,
  output logic [TAG_W-1:0]           cdb_tag,
  output logic                       nb_valid,
  output logic [TAG_W-1:0]           nb_tag
);
  localparam int NRS   = NRS_I + NRS_A + NRS_M;
  localparam int NU    = NU_I + NU_A + NU_M;
  localparam int RW    = $clog2(NRS);
  localparam int UW    = (NU > 1) ? $clog2(NU) : 1;
  localparam int LMAX  = (LAT_M > LAT_A) ? ((LAT_M > LAT_I) ? LAT_M : LAT_I)
                                         : ((LAT_A > LAT_I) ? LAT_A : LAT_I);
  localparam int CNT_W = $clog2(LMAX + 1);

  function automatic logic [1:0] rs_cls(input int r);
    return (r < NRS_I) ? 2'd0 : (r < NRS_I + NRS_A) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [1:0] u_cls(input int u);
    return (u < NU_I) ? 2'd0 : (u < NU_I + NU_A) ? 2'd1 : 2'd2;
  endfunction

  function automatic int lat_of(input logic [1:0] c);
    return (c == 2'd0) ? LAT_I : (c == 2'd1) ? LAT_A : LAT_M;
  endfunction

  function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  logic [NRS-1:0]   v_q, ex_q, nb_q, w1_q, w2_q, fin;
  logic [TAG_W-1:0] dst_q [NRS];
  logic [TAG_W-1:0] t1_q  [NRS];
  logic [TAG_W-1:0] t2_q  [NRS];
  logic [SEQ_W-1:0] sq_q  [NRS];
  logic [CNT_W-1:0] cnt_q [NRS];
  logic [UW-1:0]    un_q  [NRS];
  logic [SEQ_W-1:0] seq_q;

  logic [NU-1:0]  ubusy, sv;
  logic [RW-1:0]  sr [NU];
  logic [NRS-1:0] tk;
  logic           cdb_v, nb_v, al_v, fire;
  logic [RW-1:0]  cdb_r, nb_r, al_r;
  logic [1:0]     icls;

  assign icls = in_cls[1] ? 2'd2 : {1'b0, in_cls[0]};

  always_comb begin
    ubusy = '0;
    for (int r = 0; r < NRS; r++) begin
      fin[r] = v_q[r] && ex_q[r] && (cnt_q[r] == '0);
      for (int u = 0; u < NU; u++)
        if (v_q[r] && ex_q[r] && un_q[r] == UW'(u)) ubusy[u] = 1'b1;
    end
  end

  always_comb begin
    tk = '0;
    for (int u = 0; u < NU; u++) begin
      sv[u] = 1'b0;
      sr[u] = '0;
      if (!ubusy[u])
        for (int r = 0; r < NRS; r++)
          if (v_q[r] && !ex_q[r] && !w1_q[r] && !w2_q[r] && !tk[r] &&
              rs_cls(r) == u_cls(u) && (!sv[u] || older(sq_q[r], sq_q[sr[u]]))) begin
            sv[u] = 1'b1;
            sr[u] = RW'(r);
          end
      if (sv[u]) tk[sr[u]] = 1'b1;
    end
  end

  always_comb begin
    cdb_v = 1'b0; cdb_r = '0; nb_v = 1'b0; nb_r = '0;
    for (int r = 0; r < NRS; r++)
      if (fin[r]) begin
        if (nb_q[r]) begin
          if (!nb_v) begin nb_v = 1'b1; nb_r = RW'(r); end
        end else if (!cdb_v || older(sq_q[r], sq_q[cdb_r])) begin
          cdb_v = 1'b1; cdb_r = RW'(r);
        end
      end
  end

  always_comb begin
    al_v = 1'b0; al_r = '0;
    for (int r = NRS - 1; r >= 0; r--)
      if (!v_q[r] && rs_cls(r) == icls) begin al_v = 1'b1; al_r = RW'(r); end
  end

  assign in_ready  = al_v;
  assign fire      = in_valid && al_v;
  assign cdb_valid = cdb_v;
  assign cdb_tag   = dst_q[cdb_r];
  assign nb_valid  = nb_v;
  assign nb_tag    = dst_q[nb_r];
  assign ex_valid  = sv;

  for (genvar u = 0; u < NU; u++) begin : g_ex
    assign ex_tag[u*TAG_W +: TAG_W] = dst_q[sr[u]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0; ex_q <= '0; nb_q <= '0; w1_q <= '0; w2_q <= '0;
      seq_q <= '0;
    end else begin
      for (int r = 0; r < NRS; r++) begin
        if (v_q[r] && cdb_v) begin
          if (t1_q[r] == dst_q[cdb_r]) w1_q[r] <= 1'b0;
          if (t2_q[r] == dst_q[cdb_r]) w2_q[r] <= 1'b0;
        end
        if (ex_q[r] && cnt_q[r] != '0) cnt_q[r] <= cnt_q[r] - 1'b1;
        for (int u = 0; u < NU; u++)
          if (sv[u] && sr[u] == RW'(r)) begin
            ex_q[r]  <= 1'b1;
            cnt_q[r] <= CNT_W'(lat_of(u_cls(u)) - 1);
            un_q[r]  <= UW'(u);
          end
        if ((cdb_v && cdb_r == RW'(r)) || (nb_v && nb_r == RW'(r))) v_q[r] <= 1'b0;
        if (fire && al_r == RW'(r)) begin
          v_q[r]   <= 1'b1;
          ex_q[r]  <= 1'b0;
          nb_q[r]  <= in_nobus;
          dst_q[r] <= in_dst;
          t1_q[r]  <= in_s1;
          t2_q[r]  <= in_s2;
          w1_q[r]  <= in_s1_wait && !(cdb_v && in_s1 == dst_q[cdb_r]);
          w2_q[r]  <= in_s2_wait && !(cdb_v && in_s2 == dst_q[cdb_r]);
          sq_q[r]  <= seq_q;
        end
      end
      if (fire) seq_q <= seq_q + 1'b1;
    end
  end
endmodule

// File: rtl/tomasulo_sched_chk.sv
module tomasulo_sched_chk #(
  parameter int NRS   = 13,
  parameter int NU    = 4,
  parameter int NRS_I = 5,
  parameter int NRS_A = 4,
  parameter int RW    = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     in_cls,
  input logic           in_ready,
  input logic [NU-1:0]  ex_valid,
  input logic [NRS-1:0] v,
  input logic [NRS-1:0] ex,
  input logic [NRS-1:0] nbq,
  input logic [NRS-1:0] w1,
  input logic [NRS-1:0] w2,
  input logic [NRS-1:0] fin,
  input logic           cdb_valid,
  input logic [RW-1:0]  cdb_r
);
  localparam int NRS_M = NRS - NRS_I - NRS_A;

  for (genvar u = 0; u < NU; u++) begin : g_u
    a_r3_unit_not_pipelined: assert property (@(posedge clk) disable iff (!rst_n)
      ex_valid[u] |=> !ex_valid[u]);
  end

  for (genvar r = 0; r < NRS; r++) begin : g_r
    a_r5_loser_keeps_station: assert property (@(posedge clk) disable iff (!rst_n)
      (fin[r] && !nbq[r] && !(cdb_valid && cdb_r == RW'(r))) |=> v[r]);
    a_r6_waiting_never_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (v[r] && !ex[r] && (w1[r] || w2[r])) |=> !ex[r]);
  end

  a_r8_full_int_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(v[NRS_I-1:0]) == NRS_I && in_cls == 2'd0) |-> !in_ready);
  a_r8_full_add_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(v[NRS_I+NRS_A-1:NRS_I]) == NRS_A && in_cls == 2'd1) |-> !in_ready);
  a_r8_full_mul_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(v[NRS-1:NRS_I+NRS_A]) == NRS_M && in_cls[1]) |-> !in_ready);
endmodule

bind tomasulo_sched tomasulo_sched_chk #(
  .NRS(NRS), .NU(NU), .NRS_I(NRS_I), .NRS_A(NRS_A), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_cls(in_cls), .in_ready(in_ready),
  .ex_valid(ex_valid), .v(v_q), .ex(ex_q), .nbq(nb_q), .w1(w1_q), .w2(w2_q),
  .fin(fin), .cdb_valid(cdb_valid), .cdb_r(cdb_r)
);

// File: tb/sim_tomasulo_sched.sv
module sim_tomasulo_sched;
  localparam int TW = 5;
  localparam int NU = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_nobus = 0, in_s1_wait = 0, in_s2_wait = 0;
  logic [1:0] in_cls = 0;
  logic [TW-1:0] in_dst = 0, in_s1 = 0, in_s2 = 0;
  logic in_ready, cdb_valid, nb_valid;
  logic [NU-1:0] ex_valid;
  logic [NU*TW-1:0] ex_tag;
  logic [TW-1:0] cdb_tag, nb_tag;

  tomasulo_sched u0 (.*);

  always #2.5 clk = ~clk;

  int cyc = 0, nvec = 0, nfail = 0;
  int iss [32], st [32], wb [32], nbc [32];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    for (int u = 0; u < NU; u++) if (ex_valid[u]) st[ex_tag[u*TW +: TW]] = cyc;
    if (cdb_valid) wb[cdb_tag] = cyc;
    if (nb_valid) nbc[nb_tag] = cyc;
  end

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input int cls, input bit nob, input int dst,
                       input bit w1, input int s1, input bit w2, input int s2);
    iss[dst] = -1; st[dst] = -1; wb[dst] = -1; nbc[dst] = -1;
    in_valid = 1; in_cls = 2'(cls); in_nobus = nob; in_dst = TW'(dst);
    in_s1_wait = w1; in_s1 = TW'(s1); in_s2_wait = w2; in_s2 = TW'(s2);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    iss[dst] = cyc;
    @(negedge clk);
    in_valid = 0; in_s1_wait = 0; in_s2_wait = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int lat(input int c);
    return (c == 0) ? 1 : (c == 1) ? 6 : 12;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 ex_valid", ex_valid, 0);
    chk("R1 cdb_valid", cdb_valid, 0);
    chk("R1 nb_valid", nb_valid, 0);
    @(negedge clk);

    // R2: every class code, isolated
    for (int c = 0; c < 4; c++) begin
      issue(c, 0, 1, 0, 0, 0, 0);
      idle(16);
      chk("R2 start", st[1], iss[1] + 1);
      chk("R2 writeback", wb[1], iss[1] + 1 + lat(c > 2 ? 2 : c));
    end

    // R6: wakeup through bus, on either source, consumer issued before or in producer writeback
    for (int c = 0; c < 3; c++)
      for (int s = 0; s < 2; s++)
        for (int g = 0; g < 2; g++) begin
          issue(0, 0, 2, 0, 0, 0, 0);
          t0 = iss[2];
          if (g == 1) idle(1);
          issue(c, 0, 3, s == 0, 2, s == 1, 2);
          idle(16);
          chk("R6 producer wb", wb[2], t0 + 2);
          chk("R6 consumer start", st[3], t0 + 3);
          chk("R6 consumer wb", wb[3], t0 + 3 + lat(c));
        end

    // R3: two independent adds share one non-pipelined unit
    issue(1, 0, 4, 0, 0, 0, 0);
    issue(1, 0, 5, 0, 0, 0, 0);
    t0 = iss[4];
    idle(20);
    chk("R3 first add wb", wb[4], t0 + 7);
    chk("R3 second add start", st[5], t0 + 8);
    chk("R3 second add wb", wb[5], t0 + 14);

    // R4: two multiply units in parallel, third waits for unit 0
    issue(2, 0, 6, 0, 0, 0, 0);
    issue(3, 0, 7, 0, 0, 0, 0);
    issue(2, 0, 8, 0, 0, 0, 0);
    t0 = iss[6];
    idle(30);
    chk("R4 mul0 start", st[6], t0 + 1);
    chk("R4 mul1 start", st[7], t0 + 2);
    chk("R4 mul1 wb", wb[7], t0 + 14);
    chk("R4 mul2 start", st[8], t0 + 14);
    chk("R4 mul2 wb", wb[8], t0 + 26);

    // R5: bus conflict, older add wins, integer loser holds its unit
    issue(1, 0, 9, 0, 0, 0, 0);
    t0 = iss[9];
    idle(4);
    issue(0, 0, 10, 0, 0, 0, 0);
    issue(0, 0, 11, 0, 0, 0, 0);
    idle(12);
    chk("R5 add wb", wb[9], t0 + 7);
    chk("R5 int loser start", st[10], t0 + 6);
    chk("R5 int loser wb", wb[10], t0 + 8);
    chk("R5 held unit start", st[11], t0 + 9);
    chk("R5 held unit wb", wb[11], t0 + 10);

    // R7: store retires off the bus in the same cycle an add writes
    issue(1, 0, 12, 0, 0, 0, 0);
    t0 = iss[12];
    idle(4);
    issue(0, 1, 13, 0, 0, 0, 0);
    idle(12);
    chk("R7 store start", st[13], t0 + 6);
    chk("R7 store done", nbc[13], t0 + 7);
    chk("R7 store never on bus", wb[13], -1);
    chk("R7 add wb", wb[12], t0 + 7);
    issue(0, 0, 14, 0, 0, 0, 0);
    idle(4);
    chk("R7 station reusable", wb[14], iss[14] + 2);

    // R8 and R9: integer stations fill behind a multiply, then drain oldest first
    issue(2, 0, 20, 0, 0, 0, 0);
    t0 = iss[20];
    for (int k = 0; k < 5; k++) issue(0, 0, 21 + k, 1, 20, 0, 0);
    issue(0, 0, 26, 0, 0, 0, 0);
    idle(30);
    chk("R8 stalled issue cycle", iss[26], t0 + 16);
    for (int k = 0; k < 5; k++) begin
      chk("R9 ordered start", st[21 + k], t0 + 14 + 2 * k);
      chk("R9 ordered wb", wb[21 + k], t0 + 15 + 2 * k);
    end
    chk("R9 younger ready waits", st[26], t0 + 24);
    chk("R9 younger wb", wb[26], t0 + 25);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule